// File: doc/BRIEF.md
# Two-Level Edge-Latched Display Interrupt Aggregator

This block gathers display-pipe events into a single interrupt line for the CPU, and it does so in two levels. At the first level, each pipe has a status register. Every event source in that register has a sticky status bit and its own enable bit. When any enabled status bit is set, the pipe's event line goes high.

The second level holds three per-pipe bits:
- a live view of each event line,
- a mask bit,
- an identity bit. The identity bit records a rising edge of the pipe event line, and only when that pipe is unmasked.

The CPU interrupt is high while any identity bit is set.

Identity bits latch on an edge and not on a level. This makes the order of programming matter. Suppose a pipe event line rises while its mask bit is set. That edge is lost. Unmasking the pipe afterwards raises nothing, even while the line is still high. To get a new interrupt, software must first clear the pipe's status bits so that the line falls, and then let it rise again.

Software reaches all registers through a single-cycle read/write port. Read data is registered.

The register map uses a 4-bit address:

| Address | Register | Bit layout |
|---------|----------|------------|
| p (0 or 1) | Pipe p status | bits [3:0] are status, write 1 to clear; bits [19:16] are enables, read/write |
| 8 | Live view | bit p is the live view of pipe p |
| 9 | Mask | bit p is the mask for pipe p |
| 10 | Identity | bit p is the identity bit for pipe p, write 1 to clear |

Event inputs are numbered pipe*4 + source. Source 0 is the start-of-vblank event.

The block has no streaming data path. Every pin is a plain control or status signal, and the port never applies back-pressure.

Top module: `irqagg_top`

## Requirements
- R1: After reset, every status, enable and identity bit reads 0, the mask register reads all ones (3), the live view reads 0, and `irq` is low.
- R2: A high event input sets its status bit. That bit stays set until software writes 1 to it. Writing 0 to a status bit leaves it unchanged.
- R3: A pipe's live-view bit (bit p of address 8) is 1 exactly when some status bit of that pipe has its enable bit set. Status bits whose enable is 0 do not contribute.
- R4: When a pipe event line rises while that pipe is unmasked, the pipe's identity bit is set on the next clock edge.
- R5: A rising edge of a pipe event line while that pipe is masked does not set its identity bit. Clearing the mask later also does not set it, even if the event line is still high.
- R6: After the pipe's status bits are cleared so that its event line falls, a new event that raises the line sets the identity bit again.
- R7: Writing 1 to an identity bit clears it, and writing 0 leaves it unchanged. If a hardware set and a software clear hit the same status bit or identity bit in the same cycle, the set wins.
- R8: `irq` is high whenever any identity bit is set. It stays high until every identity bit has been cleared.
- R9: A read returns the addressed register's contents in the cycle after `reg_rd` is sampled. Enable bits and mask bits read back exactly what was last written.
- R10: A write that enables a source whose status bit is already set makes a rising edge on the event line. That edge sets the identity bit if the pipe is unmasked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| evt_pulse | input | NUM_PIPES*NUM_EVENTS | Event inputs, index pipe*NUM_EVENTS + source |
| irq | output | 1 | Interrupt to the CPU |

## Verification
The assertions check several rules on every cycle:
- Status bits stay set unless their pipe register is written.
- An identity bit is set only by an unmasked rising edge, and always after one.
- `irq` cannot fall without an identity-register write.
- The mask changes only when it is written.

Other behaviour depends on ordering, and only the bench scenarios can show it. These include:
- losing an edge that rises under the mask, and seeing nothing when the pipe is later unmasked,
- re-arming by clearing the status bits,
- a rising edge made by an enable write,
- the set-over-clear collisions, checked through registered readback.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int EN_LSB = 16;
  localparam logic [ADDR_W-1:0] ADDR_LIVE = 4'h8;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 4'h9;
  localparam logic [ADDR_W-1:0] ADDR_IDENT = 4'hA;
endpackage

// File: rtl/irqagg_pipe_stat.sv
module irqagg_pipe_stat #(
  parameter int NE = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NE-1:0] evt_i,
  input  logic          wr_i,
  input  logic [NE-1:0] clr_i,
  input  logic [NE-1:0] en_i,
  output logic [NE-1:0] status_o,
  output logic [NE-1:0] enable_o,
  output logic          pipe_evt_o
);
  logic [NE-1:0] status_q, enable_q, clr_mask;

  // Write-one-to-clear; a hardware set in the same cycle wins.
  assign clr_mask = wr_i ? clr_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
    end else begin
      status_q <= (status_q & ~clr_mask) | evt_i;
      if (wr_i) enable_q <= en_i;
    end
  end

  assign status_o   = status_q;
  assign enable_o   = enable_q;
  assign pipe_evt_o = |(status_q & enable_q);
endmodule

// File: rtl/irqagg_edge_latch.sv
module irqagg_edge_latch #(
  parameter int NP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] pipe_evt_i,
  input  logic          mask_wr_i,
  input  logic          ident_wr_i,
  input  logic [NP-1:0] wbits_i,
  output logic [NP-1:0] live_o,
  output logic [NP-1:0] mask_o,
  output logic [NP-1:0] ident_o
);
  logic [NP-1:0] evt_prev_q, mask_q, ident_q;
  logic [NP-1:0] rise, set_v, clr_v;

  assign rise  = pipe_evt_i & ~evt_prev_q;
  assign set_v = rise & ~mask_q;
  assign clr_v = ident_wr_i ? wbits_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_prev_q <= '0;
      mask_q     <= '1;
      ident_q    <= '0;
    end else begin
      evt_prev_q <= pipe_evt_i;
      ident_q    <= (ident_q & ~clr_v) | set_v;
      if (mask_wr_i) mask_q <= wbits_i;
    end
  end

  assign live_o  = pipe_evt_i;
  assign mask_o  = mask_q;
  assign ident_o = ident_q;
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
  import irqagg_pkg::*;
#(
  parameter int NUM_PIPES  = 2,
  parameter int NUM_EVENTS = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           reg_wr,
  input  logic                           reg_rd,
  input  logic [ADDR_W-1:0]              reg_addr,
  input  logic [DATA_W-1:0]              reg_wdata,
  output logic [DATA_W-1:0]              reg_rdata,
  input  logic [NUM_PIPES*NUM_EVENTS-1:0] evt_pulse,
  output logic                           irq
);
  localparam int NSTAT = NUM_PIPES * NUM_EVENTS;

  logic [NSTAT-1:0]     status_flat, enable_flat;
  logic [NUM_PIPES-1:0] pipe_evt, live, mask, ident;
  logic [DATA_W-1:0]    rd_mux, rdata_q;
  logic                 mask_wr, ident_wr;
  logic                 unused_wdata;

  assign unused_wdata = ^reg_wdata;

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
    logic pipe_wr;
    assign pipe_wr = reg_wr && (reg_addr == ADDR_W'(p));
    irqagg_pipe_stat #(.NE(NUM_EVENTS)) u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (evt_pulse[p*NUM_EVENTS +: NUM_EVENTS]),
      .wr_i       (pipe_wr),
      .clr_i      (reg_wdata[NUM_EVENTS-1:0]),
      .en_i       (reg_wdata[EN_LSB +: NUM_EVENTS]),
      .status_o   (status_flat[p*NUM_EVENTS +: NUM_EVENTS]),
      .enable_o   (enable_flat[p*NUM_EVENTS +: NUM_EVENTS]),
      .pipe_evt_o (pipe_evt[p])
    );
  end

  assign mask_wr  = reg_wr && (reg_addr == ADDR_MASK);
  assign ident_wr = reg_wr && (reg_addr == ADDR_IDENT);

  irqagg_edge_latch #(.NP(NUM_PIPES)) u_lvl2 (
    .clk        (clk),
    .rst_n      (rst_n),
    .pipe_evt_i (pipe_evt),
    .mask_wr_i  (mask_wr),
    .ident_wr_i (ident_wr),
    .wbits_i    (reg_wdata[NUM_PIPES-1:0]),
    .live_o     (live),
    .mask_o     (mask),
    .ident_o    (ident)
  );

  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NUM_PIPES; p++) begin
      if (reg_addr == ADDR_W'(p)) begin
        rd_mux[NUM_EVENTS-1:0]         = status_flat[p*NUM_EVENTS +: NUM_EVENTS];
        rd_mux[EN_LSB +: NUM_EVENTS]   = enable_flat[p*NUM_EVENTS +: NUM_EVENTS];
      end
    end
    if (reg_addr == ADDR_LIVE)  rd_mux[NUM_PIPES-1:0] = live;
    if (reg_addr == ADDR_MASK)  rd_mux[NUM_PIPES-1:0] = mask;
    if (reg_addr == ADDR_IDENT) rd_mux[NUM_PIPES-1:0] = ident;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (reg_rd) rdata_q <= rd_mux;
  end

  assign reg_rdata = rdata_q;
  assign irq       = |ident;
endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk
  import irqagg_pkg::*;
#(
  parameter int NP = 2,
  parameter int NE = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [NP*NE-1:0]  status,
  input logic [NP-1:0]     pipe_evt,
  input logic [NP-1:0]     mask,
  input logic [NP-1:0]     ident,
  input logic              irq
);
  for (genvar p = 0; p < NP; p++) begin : g_p
    for (genvar e = 0; e < NE; e++) begin : g_e
      // R2: a status bit only drops on a write to its pipe register
      p_sticky_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (status[p*NE+e] && !(reg_wr && reg_addr == ADDR_W'(p))) |=> status[p*NE+e]);
    end
    // R4: unmasked rising edge sets the identity bit
    p_edge_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pipe_evt[p]) && !mask[p]) |=> ident[p]);
    // R5: nothing but an unmasked rising edge sets it
    p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ident[p] && !($rose(pipe_evt[p]) && !mask[p])) |=> !ident[p]);
  end

  // R8: irq cannot fall without an identity-register write
  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(reg_wr && reg_addr == ADDR_IDENT)) |=> irq);

  // R9: mask changes only through its own write
  p_mask_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == ADDR_MASK) |=> $stable(mask));
endmodule

bind irqagg_top irqagg_chk #(.NP(NUM_PIPES), .NE(NUM_EVENTS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .status   (status_flat),
  .pipe_evt (pipe_evt),
  .mask     (mask),
  .ident    (ident),
  .irq      (irq)
);

// File: tb/irqagg_top_tb.sv
module irqagg_top_tb;
  import irqagg_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 2;
  localparam int NE = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0, reg_rd = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic [NP*NE-1:0]  evt_pulse = '0;
  logic              irq;

  int checks = 0;
  int errors = 0;
  logic pend = 1'b0;

  typedef struct {
    logic [DATA_W-1:0] exp;
    string             tag;
  } item_t;
  item_t sb_q[$];

  irqagg_top #(.NUM_PIPES(NP), .NUM_EVENTS(NE)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_pulse(evt_pulse), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Monitor: a read sampled at a rising edge is compared at the next falling edge.
  always @(posedge clk) pend <= reg_rd;
  always @(negedge clk) begin
    if (pend) begin
      item_t it;
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL R9: read data %h with no expected item, expected none", reg_rdata);
      end else begin
        it = sb_q.pop_front();
        if (reg_rdata !== it.exp) begin
          errors++;
          $display("FAIL %s: got %h expected %h", it.tag, reg_rdata, it.exp);
        end
      end
    end
  end

  task automatic do_read(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e, input string tag);
    reg_rd = 1'b1; reg_addr = a;
    sb_q.push_back('{exp: e, tag: tag});
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input int idx);
    evt_pulse[idx] = 1'b1;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic write_pulse(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input int idx);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; evt_pulse[idx] = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; evt_pulse = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq got %b expected %b", tag, irq, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    do_read(4'h0, 32'h0, "R1 pipe A status");
    do_read(4'h1, 32'h0, "R1 pipe B status");
    do_read(ADDR_LIVE, 32'h0, "R1 live view");
    do_read(ADDR_MASK, 32'h3, "R1 mask all set");
    do_read(ADDR_IDENT, 32'h0, "R1 identity");
    chk_irq(1'b0, "R1 irq low");

    // R9 read/write of mask and enable
    do_write(ADDR_MASK, 32'h0);
    do_read(ADDR_MASK, 32'h0, "R9 mask readback");
    do_write(4'h0, 32'h0001_0000);
    do_read(4'h0, 32'h0001_0000, "R9 enable readback");

    // R2/R3/R4 basic event on pipe A vblank
    pulse(0);
    idle(1);
    do_read(4'h0, 32'h0001_0001, "R2 status set");
    do_read(ADDR_LIVE, 32'h1, "R3 live bit");
    do_read(ADDR_IDENT, 32'h1, "R4 identity set");
    chk_irq(1'b1, "R8 irq high");

    // R2 writing 0 has no effect
    do_write(4'h0, 32'h0001_0000);
    do_read(4'h0, 32'h0001_0001, "R2 write zero keeps status");

    // R8 clearing status does not drop identity or irq
    do_write(4'h0, 32'h0001_0001);
    do_read(4'h0, 32'h0001_0000, "R2 W1C status");
    do_read(ADDR_LIVE, 32'h0, "R3 live low after clear");
    do_read(ADDR_IDENT, 32'h1, "R8 identity held");
    chk_irq(1'b1, "R8 irq held");
    do_write(ADDR_IDENT, 32'h0);
    do_read(ADDR_IDENT, 32'h1, "R7 identity write zero");
    do_write(ADDR_IDENT, 32'h1);
    do_read(ADDR_IDENT, 32'h0, "R7 identity W1C");
    chk_irq(1'b0, "R8 irq low");

    // R6 re-arm
    pulse(0);
    idle(1);
    do_read(ADDR_IDENT, 32'h1, "R6 second event");
    do_write(4'h0, 32'h0001_0001);
    do_write(ADDR_IDENT, 32'h1);

    // R5 masked edge lost
    do_write(ADDR_MASK, 32'h1);
    pulse(0);
    idle(1);
    do_read(ADDR_IDENT, 32'h0, "R5 masked edge");
    do_read(ADDR_LIVE, 32'h1, "R3 live while masked");
    do_write(ADDR_MASK, 32'h0);
    idle(2);
    do_read(ADDR_IDENT, 32'h0, "R5 unmask late");
    chk_irq(1'b0, "R5 irq stays low");
    do_write(4'h0, 32'h0001_0001);
    pulse(0);
    idle(1);
    do_read(ADDR_IDENT, 32'h1, "R6 re-arm after clear");
    do_write(4'h0, 32'h0001_0001);
    do_write(ADDR_IDENT, 32'h1);

    // R3 disabled source, R10 enable-made edge
    pulse(1);
    idle(1);
    do_read(4'h0, 32'h0001_0002, "R2 disabled source status");
    do_read(ADDR_LIVE, 32'h0, "R3 disabled source no live");
    do_read(ADDR_IDENT, 32'h0, "R3 disabled source no identity");
    do_write(4'h0, 32'h0003_0000);
    idle(1);
    do_read(ADDR_IDENT, 32'h1, "R10 enable edge");
    do_write(4'h0, 32'h0003_0002);
    do_write(ADDR_IDENT, 32'h1);

    // Pipe B
    do_write(4'h1, 32'h0001_0000);
    pulse(NE);
    idle(1);
    do_read(ADDR_IDENT, 32'h2, "R4 pipe B identity");
    do_read(4'h0, 32'h0003_0000, "R4 pipe A untouched");

    // R7 status collision
    write_pulse(4'h1, 32'h0001_0001, NE);
    do_read(4'h1, 32'h0001_0001, "R7 status set beats clear");

    // R7 identity collision
    do_write(4'h1, 32'h0001_0001);
    do_write(ADDR_IDENT, 32'h2);
    do_read(ADDR_IDENT, 32'h0, "R7 identity cleared");
    pulse(NE);
    do_write(ADDR_IDENT, 32'h2);
    do_read(ADDR_IDENT, 32'h2, "R7 identity set beats clear");
    do_write(ADDR_IDENT, 32'h2);
    do_read(ADDR_IDENT, 32'h0, "R7 identity final clear");
    chk_irq(1'b0, "R8 irq low at end");

    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule